// File: doc/BRIEF.md
# Two-State-Bit Mealy Sequencer

This block is a small synchronous sequencer. It holds two state bits, A and B, in D-type registers that share one clock. It reads one serial input bit on each rising edge. A fixed set of Boolean equations gives the next value of each state bit from the present state and the input. A single output bit is formed combinationally from the B bit and the input. Because the input takes part in the output, the output can change in the middle of a cycle when the input changes, with no clock edge in between. This makes the block a Mealy machine.

The next-state equations are:

- A(next) = A·B' + B·x'
- B(next) = A'·x + B'·x + A·B·x'

The output equation is y = B'·x.

The state bits come out on a port. Bit 1 of that port is A and bit 0 is B. This lets the surrounding logic, or a bench, follow the sequence.

An asynchronous, active-low reset clears both state bits to 00.

Top module: `mealy_ab_fsm`

## Requirements
- R1: While `rst_n` is low, `state_ab` is 2'b00, where bit 1 is A and bit 0 is B. The register is cleared as soon as reset is asserted, without waiting for a clock edge, and it stays cleared until reset is released.
- R2: From state 00, a rising edge with `x_in`=0 leaves the state at 00, and a rising edge with `x_in`=1 moves it to 01.
- R3: From state 01, `x_in`=0 moves the state to 10, and `x_in`=1 keeps it at 01.
- R4: From state 10, `x_in`=0 keeps the state at 10, and `x_in`=1 moves it to 11.
- R5: From state 11, `x_in`=0 keeps the state at 11, and `x_in`=1 returns it to 00.
- R6: `y_out` is 1 exactly when B (bit 0 of the state) is 0 and `x_in` is 1. The A bit has no effect on it, so `y_out` equals `x_in` in states 00 and 10 and is 0 in states 01 and 11.
- R7: `y_out` is not registered. A change on `x_in` reaches `y_out` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for both state bits |
| rst_n | input | 1 | Asynchronous active-low reset to state 00 |
| x_in | input | 1 | Serial input bit |
| y_out | output | 1 | Combinational Mealy output |
| state_ab | output | 2 | Present state, with A in bit 1 and B in bit 0 |

## Verification
The clocked properties assume two things:

- `x_in` is settled at each rising edge.
- `rst_n` is only released between edges, so that each transition can be attributed to the sampled input of the previous cycle.

The bench keeps to these assumptions. It changes `x_in` only just after a falling edge, and it moves `rst_n` only in the low phase. It also asserts reset once in the middle of a run, from a non-zero state, so that the clearing is seen without a clock edge. While reset holds the state at 00, the bench toggles `x_in` to show the output following the input combinationally.

// File: rtl/mealy_ab_pkg.sv
`timescale 1ns/1ps
package mealy_ab_pkg;
  parameter int STATE_W = 2;
  localparam int BIT_A = STATE_W - 1;
  localparam int BIT_B = 0;
  typedef logic [STATE_W-1:0] ab_state_t;
  localparam ab_state_t ST_RESET = '0;
endpackage

// File: rtl/mab_next_logic.sv
`timescale 1ns/1ps
module mab_next_logic
  import mealy_ab_pkg::*;
(
  input  ab_state_t cur_st,
  input  logic      x_bit,
  output ab_state_t nxt_st
);
  logic a_q, b_q;

  always_comb begin
    a_q = cur_st[BIT_A];
    b_q = cur_st[BIT_B];
    nxt_st = ST_RESET;
    // sum-of-products next-state equations
    nxt_st[BIT_A] = (a_q & ~b_q) | (b_q & ~x_bit);
    nxt_st[BIT_B] = (~a_q & x_bit) | (~b_q & x_bit) | (a_q & b_q & ~x_bit);
  end
endmodule

// File: rtl/mab_out_logic.sv
`timescale 1ns/1ps
module mab_out_logic
  import mealy_ab_pkg::*;
(
  input  ab_state_t cur_st,
  input  logic      x_bit,
  output logic      y_bit
);
  logic b_q;

  always_comb begin
    b_q   = cur_st[BIT_B];
    y_bit = ~b_q & x_bit;
  end
endmodule

// File: rtl/mab_state_reg.sv
`timescale 1ns/1ps
module mab_state_reg
  import mealy_ab_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ab_state_t d_st,
  output ab_state_t q_st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_st <= ST_RESET;
    end else begin
      q_st <= d_st;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $rose(rst_n) |-> (q_st == ST_RESET)); // R1
endmodule

// File: rtl/mealy_ab_fsm.sv
`timescale 1ns/1ps
module mealy_ab_fsm
  import mealy_ab_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               x_in,
  output logic               y_out,
  output logic [STATE_W-1:0] state_ab
);
  ab_state_t cur_st;
  ab_state_t nxt_st;

  mab_next_logic u_next (
    .cur_st (cur_st),
    .x_bit  (x_in),
    .nxt_st (nxt_st)
  );

  mab_state_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_st  (nxt_st),
    .q_st  (cur_st)
  );

  mab_out_logic u_out (
    .cur_st (cur_st),
    .x_bit  (x_in),
    .y_bit  (y_out)
  );

  assign state_ab = cur_st;

  AST_FROM_S00: assert property (@(posedge clk) disable iff (!rst_n)
    (state_ab == 2'b00) |=> (state_ab == ($past(x_in) ? 2'b01 : 2'b00))); // R2
  AST_FROM_S01: assert property (@(posedge clk) disable iff (!rst_n)
    (state_ab == 2'b01) |=> (state_ab == ($past(x_in) ? 2'b01 : 2'b10))); // R3
  AST_FROM_S10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_ab == 2'b10) |=> (state_ab == ($past(x_in) ? 2'b11 : 2'b10))); // R4
  AST_FROM_S11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_ab == 2'b11) |=> (state_ab == ($past(x_in) ? 2'b00 : 2'b11))); // R5
  AST_Y_NEEDS_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    y_out |-> (!state_ab[BIT_B] && x_in)); // R6
endmodule

// File: tb/mealy_ab_fsm_tb.sv
`timescale 1ns/1ps
module mealy_ab_fsm_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       x_in;
  logic       y_out;
  logic [1:0] state_ab;

  always #5 clk = ~clk;

  mealy_ab_fsm u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .x_in     (x_in),
    .y_out    (y_out),
    .state_ab (state_ab)
  );

  typedef struct {
    logic [1:0] from_st;
    logic       exp_y;
    logic [1:0] exp_st;
  } item_t;

  item_t      sb_q[$];
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;
  logic [1:0] model_st;

  function automatic logic [1:0] ref_next(logic [1:0] s, logic xv);
    case (s)
      2'b00:   return xv ? 2'b01 : 2'b00;
      2'b01:   return xv ? 2'b01 : 2'b10;
      2'b10:   return xv ? 2'b11 : 2'b10;
      default: return xv ? 2'b00 : 2'b11;
    endcase
  endfunction

  function automatic logic ref_y(logic [1:0] s, logic xv);
    return xv && (s == 2'b00 || s == 2'b10);
  endfunction

  function automatic string req_of(logic [1:0] s);
    case (s)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(logic xv);
    item_t it;
    @(negedge clk);
    x_in = xv;
    it.from_st = model_st;
    it.exp_y   = ref_y(model_st, xv);
    it.exp_st  = ref_next(model_st, xv);
    sb_q.push_back(it);
    model_st = it.exp_st;
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(posedge clk);
    #3;
  endtask

  // monitor: compare output mid low phase, state just after the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check("R6", "y_out", {1'b0, y_out}, {1'b0, it.exp_y});
        @(posedge clk);
        #1;
        check(req_of(it.from_st), "state_ab", state_ab, it.exp_st);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog requirement=all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    x_in     = 1'b0;
    model_st = 2'b00;
    #1;
    check("R1", "state in reset", state_ab, 2'b00);
    #2 x_in = 1'b1;
    #1 check("R7", "y follows x=1", {1'b0, y_out}, 2'b01);
    x_in = 1'b0;
    #1 check("R7", "y follows x=0", {1'b0, y_out}, 2'b00);
    x_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", "state held in reset", state_ab, 2'b00);
    @(negedge clk);
    x_in  = 1'b0;
    rst_n = 1'b1;

    // walk every transition of the table
    step(1'b0); step(1'b1); step(1'b1); step(1'b0);
    step(1'b0); step(1'b1); step(1'b0); step(1'b1);
    step(1'b1); step(1'b0); step(1'b1); step(1'b1);
    step(1'b1); step(1'b0); step(1'b1); step(1'b0);
    drain();

    // asynchronous reset from a non-zero state (model is at 11 here)
    check("R5", "state before mid reset", state_ab, model_st);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R1", "async clear", state_ab, 2'b00);
    model_st = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    x_in  = 1'b0;

    step(1'b1); step(1'b0); step(1'b1); step(1'b0);
    step(1'b1); step(1'b1); step(1'b0); step(1'b0);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule